// File: doc/BRIEF.md
# Serial Cyclic-Code Pattern Labeller and Checker

This block attaches a short cyclic check label to a 64-bit state vector that circulates one bit per clock, and later judges whether a vector read back from the same ring still carries a consistent label. A vector holds 58 information bits followed by 6 label bits, most significant bit first. A slot marker input flags the first slot, the six label slots and the last slot of every 64-slot frame. The operating mode is sampled in the first slot of each frame.

In insert mode the block passes the information bits through and divides them by the generator x^6 + x + 1 as they stream past. In the six label slots it shifts out the remainder in place of whatever arrives on the input, so the stored vector is a full codeword. In check mode, used once the network has settled on a state, the block recomputes the remainder over the information bits and compares it bit by bit with the incoming label slots. It then registers a verdict that tells a stored pattern apart from a spurious state. The serial output in check mode is the input delayed by one clock.

Top module: `cyclic_label_unit`

## Requirements
- R1: While reset is high, and on the first clock after it, `bit_out` and `code_ok` are 0.
- R2: In every slot whose `mark_label` is 0, `bit_out` one clock later equals `bit_in` of that slot, in either mode.
- R3: In an insert frame, `bit_out` in the clock after label slot j (j = 0..5) equals remainder bit 5-j of D(x)*x^6 divided by x^6 + x + 1. D(x) is the 58 information bits with the first slot as the coefficient of x^57.
- R4: In an insert frame the values on `bit_in` during the label slots have no effect on `bit_out` or on `code_ok`.
- R5: In the clock after the last slot of a check frame, `code_ok` is 1 exactly when all six label bits received equal the remainder of R3 computed over the received information bits.
- R6: A check frame carrying a valid codeword with any single bit inverted yields `code_ok` = 0.
- R7: `code_ok` changes only in the clock after the last slot of a check frame. Insert frames and other slots leave it unchanged.
- R8: The mode (`mode_ins` = 1 insert, 0 check) is taken from the first slot of a frame only. Changes later in the frame are ignored. The remainder restarts at every first slot, so back-to-back frames are independent.
- R9: In a check frame the label slots also pass through: `bit_out` one clock later equals `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ins | input | 1 | 1 = insert label, 0 = check label; sampled in the first slot |
| bit_in | input | 1 | Serial vector bit for the current slot |
| mark_first | input | 1 | High in slot 0 of a frame |
| mark_label | input | 1 | High in the six label slots (58..63) |
| mark_last | input | 1 | High in slot 63 of a frame |
| bit_out | output | 1 | Registered serial output, one clock behind the slot |
| code_ok | output | 1 | Registered verdict of the most recent check frame |

## Verification
Each serial result is due one clock after the slot that produced it, and the verdict is due one clock after the last slot. The bench drives every slot on the falling edge and samples `bit_out` and `code_ok` one nanosecond after the following rising edge, so every sample lands in the clock where the result appears. Expected labels come from long division of the 64-bit polynomial in the bench. All 64 single-bit corruptions of a codeword are swept, and mode changes in the middle of a frame are included.

// File: rtl/cyclic_label_pkg.sv
package cyclic_label_pkg;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned LBL_W     = 6;
  localparam int unsigned INFO_LEN  = FRAME_LEN - LBL_W;
  // low-order terms of x^6 + x + 1 (the x^6 term is implied)
  localparam logic [LBL_W-1:0] GEN_TAPS = 6'b000011;

  typedef enum logic {
    MODE_CHECK  = 1'b0,
    MODE_INSERT = 1'b1
  } lbl_mode_e;
endpackage

// File: rtl/label_lfsr.sv
module label_lfsr #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] TAPS = 6'b000011
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic feed,
  input  logic drain,
  input  logic din,
  output logic rem_msb,
  output logic rem_zero
);
  logic [W-1:0] rem_q;
  logic [W-1:0] base;
  logic         fb;

  always_comb begin
    base = restart ? '0 : rem_q;
    fb   = din ^ base[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (feed) begin
      rem_q <= {base[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
    end else if (drain) begin
      rem_q <= {rem_q[W-2:0], 1'b0};
    end
  end

  assign rem_msb  = rem_q[W-1];
  assign rem_zero = (rem_q == '0);
endmodule

// File: rtl/label_match.sv
module label_match (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cmp_en,
  input  logic verdict_en,
  input  logic rx_bit,
  input  logic exp_bit,
  output logic code_ok
);
  logic mis_q;
  logic err_now;

  assign err_now = cmp_en & (rx_bit ^ exp_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_q   <= 1'b0;
      code_ok <= 1'b0;
    end else begin
      if (restart)     mis_q <= 1'b0;
      else if (cmp_en) mis_q <= mis_q | err_now;
      if (verdict_en)  code_ok <= ~(mis_q | err_now);
    end
  end
endmodule

// File: rtl/cyclic_label_unit.sv
module cyclic_label_unit
  import cyclic_label_pkg::*;
#(
  parameter int unsigned LW = LBL_W,
  parameter logic [LW-1:0] TAPS = GEN_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_ins,
  input  logic bit_in,
  input  logic mark_first,
  input  logic mark_label,
  input  logic mark_last,
  output logic bit_out,
  output logic code_ok
);
  lbl_mode_e mode_q;
  lbl_mode_e mode_now;
  logic      ins_now;
  logic      rem_msb;
  logic      rem_zero;

  always_comb begin
    mode_now = mark_first ? lbl_mode_e'(mode_ins) : mode_q;
    ins_now  = (mode_now == MODE_INSERT);
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_CHECK;
    else if (mark_first) mode_q <= lbl_mode_e'(mode_ins);
  end

  label_lfsr #(.W(LW), .TAPS(TAPS)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .restart (mark_first),
    .feed    (~mark_label),
    .drain   (mark_label),
    .din     (bit_in),
    .rem_msb (rem_msb),
    .rem_zero(rem_zero)
  );

  label_match u_match (
    .clk       (clk),
    .rst       (rst),
    .restart   (mark_first),
    .cmp_en    (mark_label & ~ins_now),
    .verdict_en(mark_last & ~ins_now),
    .rx_bit    (bit_in),
    .exp_bit   (rem_msb),
    .code_ok   (code_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) bit_out <= 1'b0;
    else     bit_out <= (mark_label & ins_now) ? rem_msb : bit_in;
  end
endmodule

// File: rtl/cyclic_label_checker.sv
module cyclic_label_checker (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic mark_label,
  input logic mark_last,
  input logic ins_now,
  input logic rem_zero,
  input logic bit_out,
  input logic code_ok
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!bit_out && !code_ok));

  a_r2_info_pass: assert property (@(posedge clk) disable iff (rst)
    !mark_label |=> (bit_out == $past(bit_in)));

  a_r9_check_label_pass: assert property (@(posedge clk) disable iff (rst)
    (mark_label && !ins_now) |=> (bit_out == $past(bit_in)));

  a_r7_verdict_hold: assert property (@(posedge clk) disable iff (rst)
    !(mark_last && !ins_now) |=> $stable(code_ok));

  // R3: six label shifts empty the remainder by the end of the frame
  a_r3_rem_drained: assert property (@(posedge clk) disable iff (rst)
    mark_last |=> rem_zero);
endmodule

bind cyclic_label_unit cyclic_label_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .mark_label(mark_label),
  .mark_last (mark_last),
  .ins_now   (ins_now),
  .rem_zero  (rem_zero),
  .bit_out   (bit_out),
  .code_ok   (code_ok)
);

// File: tb/cyclic_label_unit_tb.sv
`timescale 1ns/1ps
module cyclic_label_unit_tb;
  logic clk = 1'b0;
  logic rst, mode_ins, bit_in, mark_first, mark_label, mark_last;
  logic bit_out, code_ok;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cyclic_label_unit u_dut (
    .clk(clk), .rst(rst), .mode_ins(mode_ins), .bit_in(bit_in),
    .mark_first(mark_first), .mark_label(mark_label), .mark_last(mark_last),
    .bit_out(bit_out), .code_ok(code_ok)
  );

  // remainder of D(x)*x^6 mod x^6+x+1 by long division
  function automatic logic [5:0] label_of(input logic [57:0] d);
    logic [63:0] v;
    v = {d, 6'b0};
    for (int i = 63; i >= 6; i--)
      if (v[i]) v = v ^ (64'h43 << (i - 6));
    return v[5:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame; mode_first in slot 0, mode_rest afterwards
  task automatic run_frame(input logic [63:0] vec, input logic mode_first,
                           input logic mode_rest, output logic [63:0] outv);
    for (int s = 0; s < 64; s++) begin
      @(negedge clk);
      bit_in     = vec[63-s];
      mode_ins   = (s == 0) ? mode_first : mode_rest;
      mark_first = (s == 0);
      mark_label = (s >= 58);
      mark_last  = (s == 63);
      @(posedge clk);
      #1;
      outv[63-s] = bit_out;
    end
    @(negedge clk);
    mark_first = 0; mark_label = 0; mark_last = 0; bit_in = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] o, cw, bad;
    logic [57:0] d;
    logic okv;
    rst = 1; mode_ins = 0; bit_in = 0; mark_first = 0; mark_label = 0; mark_last = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset bit_out", {63'b0, bit_out}, 64'd0);
    chk("R1 reset code_ok", {63'b0, code_ok}, 64'd0);
    rst = 0;

    // insert with varied data; garbage in label slots
    for (int t = 0; t < 6; t++) begin
      case (t)
        0: d = '0;
        1: d = '1;
        2: d = 58'h2AA_AAAA_AAAA_AAAA;
        3: d = 58'h1;
        4: d = 58'h200_0000_0000_0000;
        default: d = 58'h13C_5A0F_E712_3D94;
      endcase
      run_frame({d, 6'(t * 11 + 5)}, 1'b1, 1'b1, o);
      chk("R2 insert info passthrough", {6'b0, o[63:6]}, {6'b0, d});
      chk("R3 R4 inserted label", {58'b0, o[5:0]}, {58'b0, label_of(d)});
      chk("R4 R7 code_ok unchanged by insert", {63'b0, code_ok}, 64'd0);
    end

    // good codeword checks
    d  = 58'h0F1_2345_6789_ABCD;
    cw = {d, label_of(d)};
    run_frame(cw, 1'b0, 1'b0, o);
    chk("R5 valid codeword accepted", {63'b0, code_ok}, 64'd1);
    chk("R9 check passthrough", o, cw);

    // every single-bit corruption
    for (int b = 0; b < 64; b++) begin
      bad = cw ^ (64'd1 << b);
      run_frame(bad, 1'b0, 1'b0, o);
      chk("R6 single-bit error rejected", {63'b0, code_ok}, 64'd0);
    end

    // mode switched to insert mid-frame: still a check frame
    run_frame(cw, 1'b0, 1'b1, o);
    chk("R8 mode latched at first slot (verdict)", {63'b0, code_ok}, 64'd1);
    chk("R8 R9 label not replaced", o, cw);

    // mode switched to check mid-frame: still an insert frame
    run_frame({d, 6'h2A}, 1'b1, 1'b0, o);
    chk("R8 insert kept after mode change", {58'b0, o[5:0]}, {58'b0, label_of(d)});
    chk("R7 verdict held through insert frame", {63'b0, code_ok}, 64'd1);

    // wrong label, then hold between frames
    run_frame({d, label_of(d) ^ 6'h20}, 1'b0, 1'b0, o);
    chk("R5 wrong label rejected", {63'b0, code_ok}, 64'd0);
    repeat (5) @(negedge clk);
    chk("R7 verdict held while idle", {63'b0, code_ok}, 64'd0);

    // a sequence of random codewords checked back-to-back
    for (int t = 0; t < 8; t++) begin
      d = {$urandom(), $urandom()};
      run_frame({d, 6'h00}, 1'b1, 1'b1, o);
      cw = o;
      run_frame(cw, 1'b0, 1'b0, o);
      okv = code_ok;
      chk("R5 R8 round trip", {63'b0, okv}, 64'd1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule